// File: doc/BRIEF.md
# Dual-Counter PWM Timer

This block is a timer with two counters of parameter width. Each counter has a load value and a bit-mapped control word, and each one marks the end of its count interval with a pulse one clock wide. Either counter can count up or down. At the end of an interval it either restarts or stops. When both counters are armed for pulse-width mode, they drive one output: counter 0's expiry starts the high phase and fixes the period, and counter 1's expiry ends it and fixes the high time. Because of this pairing, both period and high time can change from one pulse to the next.

Software reaches the four registers through a plain write port with a combinational read-back. The block brings out both expiry pulses, each gated by its own enable bit, a combined interrupt line and the pulse-width output.

Top module: `twin_timer_pwm`

## Requirements
- R1: After reset every register reads 0, and `expOut0`, `expOut1`, `irq` and `pwmOut` are low.
- R2: Register addresses are 0 = control 0, 1 = load 0, 2 = control 1, 3 = load 1. Control bits: 9 pulse-width enable, 8 interrupt flag, 7 run, 6 interrupt enable, 5 load strobe, 4 auto-reload, 2 expiry-output enable, 1 down count, 0 capture mode. Writing bit 5 does not store it, so it and the other unlisted bits read back 0. A load register reads back what was written.
- R3: In up count (bit 1 = 0) the load strobe sets the counter to 0. The counter expires when it equals its load value L, so with auto-reload an expiry occurs every L+1 clocks. The expiry shows on `expOutN` only while bit 2 is 1.
- R4: In down count (bit 1 = 1) the load strobe sets the counter to L and it expires on reaching 0, every L+1 clocks with auto-reload.
- R5: With bit 4 = 0 the counter stops after one expiry and gives no further pulse until the next load strobe.
- R6: A load value of 0 gives an expiry on every clock in both directions.
- R7: An expiry while bit 6 = 1 sets that channel's flag (control bit 8). Writing 1 to bit 8 clears it. `irq` is the OR of both flags, and with bit 6 = 0 no flag is set.
- R8: With bits 9 and 7 set in both controls, `pwmOut` rises the clock after a counter 0 expiry and falls the clock after a counter 1 expiry. Counter 1 restarts at every counter 0 expiry, so the high time is L1+1 clocks and the period is L0+1 clocks.
- R9: If L1 >= L0 in pulse-width mode, `pwmOut` stays high.
- R10: If bit 9 or bit 7 is clear in either control, `pwmOut` is low.
- R11: A load value written during an interval takes effect at the next restart of that counter. The pulse under way keeps its old high time and period.
- R12: With bit 0 = 1 (capture) the counter holds and never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| wrData | input | CNT_W | Write data |
| rdData | output | CNT_W | Read data for `regAddr` |
| expOut0 | output | 1 | Counter 0 expiry pulse (gated by bit 2) |
| expOut1 | output | 1 | Counter 1 expiry pulse (gated by bit 2) |
| irq | output | 1 | OR of the two interrupt flags |
| pwmOut | output | 1 | Pulse-width output |

## Verification
The assertions assume that software issues a load strobe before it relies on expiry timing, because a counter left at zero after reset fires at once. They also assume that `CNT_W` is at least 10, so that the control word fits in the data path. The pulse-width checks assume that the run and mode bits change only through register writes and never in the middle of a property's window. The stimulus drives writes at the falling edge, strobes the load in the same write that sets run, and stops a counter before it clears that counter's flag. This keeps a set and a clear from landing in the same cycle.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  localparam int NUM_CH     = 2;
  localparam int CTL_W      = 10;
  localparam int BIT_PWM    = 9;
  localparam int BIT_FLAG   = 8;
  localparam int BIT_RUN    = 7;
  localparam int BIT_IEN    = 6;
  localparam int BIT_LOAD   = 5;
  localparam int BIT_RELOAD = 4;
  localparam int BIT_GEN    = 2;
  localparam int BIT_DOWN   = 1;
  localparam int BIT_CAPT   = 0;
  localparam logic [CTL_W-1:0] CTL_KEEP = 10'h2D7;

  typedef struct packed {
    logic load;
    logic run;
    logic down;
    logic reload;
    logic capture;
  } chanCmd_t;
endpackage

// File: rtl/twin_timer_ctrl.sv
module twin_timer_ctrl
  import twin_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int ADDR_W = $clog2(NUM_CH) + 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                regAddr,
  input  logic [CNT_W-1:0]                 wrData,
  input  logic [NUM_CH-1:0]                expire,
  output logic [CNT_W-1:0]                 rdData,
  output chanCmd_t [NUM_CH-1:0]            cmd,
  output logic [NUM_CH-1:0][CNT_W-1:0]     loadVal,
  output logic [NUM_CH-1:0]                genEn,
  output logic                             pwmActive,
  output logic                             irq
);
  logic [NUM_CH-1:0][CNT_W-1:0] ctlView;
  logic [NUM_CH-1:0]            flags;
  logic [NUM_CH-1:0]            armed;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CTL_W-1:0] ctlQ;
    logic [CNT_W-1:0] lrQ;
    logic             flagQ;
    logic             selCtl;
    logic             selLr;

    assign selCtl = wrEn && (regAddr == ADDR_W'(2 * ch));
    assign selLr  = wrEn && (regAddr == ADDR_W'(2 * ch + 1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctlQ  <= '0;
        lrQ   <= '0;
        flagQ <= 1'b0;
      end else begin
        if (selCtl) ctlQ <= wrData[CTL_W-1:0] & CTL_KEEP;
        if (selLr)  lrQ  <= wrData;
        if (expire[ch] && ctlQ[BIT_IEN]) flagQ <= 1'b1;
        else if (selCtl && wrData[BIT_FLAG]) flagQ <= 1'b0;
      end
    end

    assign cmd[ch] = '{load:    selCtl && wrData[BIT_LOAD],
                       run:     ctlQ[BIT_RUN],
                       down:    ctlQ[BIT_DOWN],
                       reload:  ctlQ[BIT_RELOAD],
                       capture: ctlQ[BIT_CAPT]};
    assign loadVal[ch] = lrQ;
    assign genEn[ch]   = ctlQ[BIT_GEN];
    assign flags[ch]   = flagQ;
    assign armed[ch]   = ctlQ[BIT_PWM] && ctlQ[BIT_RUN];
    assign ctlView[ch] = {{(CNT_W-CTL_W){1'b0}}, ctlQ[BIT_PWM], flagQ, ctlQ[BIT_RUN:0]};

    // R7: enabled expiry raises the flag
    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rstN)
      (expire[ch] && ctlQ[BIT_IEN]) |=> flagQ);
    // R7: write-one clear with no concurrent set drops the flag
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
      (selCtl && wrData[BIT_FLAG] && !(expire[ch] && ctlQ[BIT_IEN])) |=> !flagQ);
  end

  assign pwmActive = &armed;
  assign irq       = |flags;

  always_comb begin
    if (regAddr[0]) rdData = loadVal[regAddr[ADDR_W-1:1]];
    else            rdData = ctlView[regAddr[ADDR_W-1:1]];
  end
endmodule

// File: rtl/twin_timer_dp.sv
module twin_timer_dp
  import twin_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  chanCmd_t [NUM_CH-1:0]        cmd,
  input  logic [NUM_CH-1:0][CNT_W-1:0] loadVal,
  input  logic                         pwmActive,
  output logic [NUM_CH-1:0]            expire,
  output logic                         pwmOut
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cnt
    logic [CNT_W-1:0] cntQ;
    logic [CNT_W-1:0] limitQ;
    logic [CNT_W-1:0] startVal;
    logic             doneQ;
    logic             live;
    logic             hit;
    logic             restart;

    if (ch == 0) begin : g_lead
      assign restart = 1'b0;
    end else begin : g_follow
      assign restart = pwmActive && expire[0];
    end

    assign live       = cmd[ch].run && !cmd[ch].capture && !doneQ;
    assign hit        = cmd[ch].down ? (cntQ == '0) : (cntQ == limitQ);
    assign expire[ch] = live && hit;
    assign startVal   = cmd[ch].down ? loadVal[ch] : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ   <= '0;
        limitQ <= '0;
        doneQ  <= 1'b0;
      end else if (cmd[ch].load || restart) begin
        cntQ   <= startVal;
        limitQ <= loadVal[ch];
        doneQ  <= 1'b0;
      end else if (expire[ch]) begin
        if (cmd[ch].reload) begin
          cntQ   <= startVal;
          limitQ <= loadVal[ch];
        end else begin
          doneQ  <= 1'b1;
        end
      end else if (live) begin
        cntQ <= cmd[ch].down ? cntQ - 1'b1 : cntQ + 1'b1;
      end
    end

    // R5: a stopped counter keeps its value until reloaded
    assert_hold_still_R5: assert property (@(posedge clk) disable iff (!rstN)
      (doneQ && !cmd[ch].load && !restart) |=> $stable(cntQ));
    // R12: capture mode freezes the counter
    assert_capture_still_R12: assert property (@(posedge clk) disable iff (!rstN)
      (cmd[ch].capture && !cmd[ch].load && !restart) |=> $stable(cntQ));
  end

  always_ff @(posedge clk) begin
    if (!rstN)               pwmOut <= 1'b0;
    else if (!pwmActive)     pwmOut <= 1'b0;
    else if (expire[0])      pwmOut <= 1'b1;
    else if (expire[1])      pwmOut <= 1'b0;
  end

  // R10: output falls when the pair is not armed
  assert_pwm_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !pwmActive |=> !pwmOut);
  // R8: a rise always follows a period expiry
  assert_pwm_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> $past(expire[0]));
  // R8: a fall while armed always follows a high-time expiry
  assert_pwm_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pwmOut) && $past(pwmActive)) |-> $past(expire[1]));
endmodule

// File: rtl/twin_timer_pwm.sv
module twin_timer_pwm
  import twin_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic             expOut0,
  output logic             expOut1,
  output logic             irq,
  output logic             pwmOut
);
  chanCmd_t [NUM_CH-1:0]        cmd;
  logic [NUM_CH-1:0][CNT_W-1:0] loadVal;
  logic [NUM_CH-1:0]            genEn;
  logic [NUM_CH-1:0]            expire;
  logic                         pwmActive;

  twin_timer_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .expire(expire), .rdData(rdData), .cmd(cmd), .loadVal(loadVal),
    .genEn(genEn), .pwmActive(pwmActive), .irq(irq)
  );

  twin_timer_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .loadVal(loadVal),
    .pwmActive(pwmActive), .expire(expire), .pwmOut(pwmOut)
  );

  assign expOut0 = expire[0] && genEn[0];
  assign expOut1 = expire[1] && genEn[1];
endmodule

// File: tb/twin_timer_pwm_tb_top.sv
`timescale 1ns/1ps
module twin_timer_pwm_tb_top;
  localparam logic [1:0] A_CTL0 = 2'd0, A_LD0 = 2'd1, A_CTL1 = 2'd2, A_LD1 = 2'd3;
  // each row: load 0, load 1, expected high clocks, expected period clocks
  localparam int VEC [0:4][0:3] = '{'{9, 3, 4, 10}, '{19, 0, 1, 20}, '{15, 14, 15, 16},
                                    '{31, 10, 11, 32}, '{7, 6, 7, 8}};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        expOut0, expOut1, irq, pwmOut;
  int          nChecks = 0;
  int          nFails = 0;

  always #4 clk = ~clk;

  twin_timer_pwm dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .expOut0(expOut0), .expOut1(expOut1), .irq(irq), .pwmOut(pwmOut)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = rdData;
  endtask

  task automatic nextExp0(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!expOut0 && gap < 1000);
  endtask

  task automatic waitRise();
    while (pwmOut) @(negedge clk);
    while (!pwmOut) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int per);
    hi = 0; per = 0;
    while (pwmOut) begin hi++; per++; @(negedge clk); end
    while (!pwmOut) begin per++; @(negedge clk); end
  endtask

  task automatic countExp0(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (expOut0) n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int g, n, hi, per;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R1 register after reset", v, 0);
    end
    chk({expOut0, expOut1, irq, pwmOut} == 4'b0, "R1 outputs after reset",
        {expOut0, expOut1, irq, pwmOut}, 0);

    // R2: map and read-back
    wr(A_LD1, 32'h1234_5678); rd(A_LD1, v);
    chk(v == 32'h1234_5678, "R2 load register read-back", v, 32'h1234_5678);
    wr(A_CTL1, 32'hFFFF_FFFF); rd(A_CTL1, v);
    chk(v == 32'h2D7, "R2 unlisted and strobe bits read 0", v, 32'h2D7);
    wr(A_CTL1, 0);
    wr(A_LD0, 4); wr(A_CTL0, 32'hB4); rd(A_CTL0, v);
    chk(v == 32'h94, "R2 load strobe not stored", v, 32'h94);

    // R3: up-count interval L+1
    nextExp0(g); nextExp0(g);
    chk(g == 5, "R3 up-count expiry interval", g, 5);
    nextExp0(g);
    chk(g == 5, "R3 up-count interval repeats", g, 5);

    // R4: down-count interval
    wr(A_CTL0, 0); wr(A_LD0, 6); wr(A_CTL0, 32'hB6);
    nextExp0(g); nextExp0(g);
    chk(g == 7, "R4 down-count expiry interval", g, 7);

    // R5: hold after single expiry, restart on load
    wr(A_CTL0, 0); wr(A_LD0, 3); wr(A_CTL0, 32'hA4);
    countExp0(30, n);
    chk(n == 1, "R5 hold gives one expiry", n, 1);
    wr(A_CTL0, 32'hA4);
    countExp0(30, n);
    chk(n == 1, "R5 new load strobe gives one more", n, 1);

    // R6: zero load fires every clock, both directions
    wr(A_CTL0, 0); wr(A_LD0, 0); wr(A_CTL0, 32'hB4);
    n = 0;
    for (int i = 0; i < 8; i++) begin if (expOut0) n++; @(negedge clk); end
    chk(n == 8, "R6 zero load up-count every clock", n, 8);
    wr(A_CTL0, 32'hB6);
    n = 0;
    for (int i = 0; i < 8; i++) begin if (expOut0) n++; @(negedge clk); end
    chk(n == 8, "R6 zero load down-count every clock", n, 8);

    // R12: capture mode never expires
    wr(A_CTL0, 0); wr(A_LD0, 2); wr(A_CTL0, 32'hB5);
    countExp0(20, n);
    chk(n == 0, "R12 capture mode no expiry", n, 0);

    // R7 and R3 gating: irq enabled, expiry output disabled
    wr(A_CTL0, 0); wr(A_LD0, 5); wr(A_CTL0, 32'hF0);
    countExp0(12, n);
    chk(n == 0, "R3 expiry output gated by bit 2", n, 0);
    chk(irq == 1'b1, "R7 irq set after expiry", irq, 1);
    rd(A_CTL0, v);
    chk(v == 32'h1D0, "R7 flag reads in bit 8", v, 32'h1D0);
    wr(A_CTL0, 32'h40); wr(A_CTL0, 32'h100);
    chk(irq == 1'b0, "R7 write-one clears flag", irq, 0);
    wr(A_LD0, 2); wr(A_CTL0, 32'hB0);
    repeat (20) @(negedge clk);
    chk(irq == 1'b0, "R7 no flag with interrupt disabled", irq, 0);

    // R10: output held low when channel 1 lacks the mode bit
    wr(A_CTL0, 0); wr(A_LD0, 9); wr(A_LD1, 3);
    wr(A_CTL1, 32'hB4); wr(A_CTL0, 32'h2B4);
    n = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwmOut) n++; end
    chk(n == 0, "R10 output low when not armed", n, 0);

    // R8: table of period and high-time pairs
    for (int k = 0; k < 5; k++) begin
      wr(A_CTL0, 0);
      wr(A_LD0, VEC[k][0]); wr(A_LD1, VEC[k][1]);
      wr(A_CTL1, 32'h2B4); wr(A_CTL0, 32'h2B4);
      waitRise();
      measure(hi, per);
      chk(hi == VEC[k][2], "R8 high time", hi, VEC[k][2]);
      chk(per == VEC[k][3], "R8 period", per, VEC[k][3]);
    end

    // R9: high time not below period keeps output high
    wr(A_CTL0, 0); wr(A_LD0, 7); wr(A_LD1, 9);
    wr(A_CTL1, 32'h2B4); wr(A_CTL0, 32'h2B4);
    waitRise();
    n = 0;
    for (int i = 0; i < 40; i++) begin if (pwmOut) n++; @(negedge clk); end
    chk(n == 40, "R9 output stays high", n, 40);

    // R11: new values apply from the next pulse
    wr(A_CTL0, 0); wr(A_LD0, 19); wr(A_LD1, 4);
    wr(A_CTL1, 32'h2B4); wr(A_CTL0, 32'h2B4);
    waitRise();
    fork
      measure(hi, per);
      begin wr(A_LD0, 11); wr(A_LD1, 7); end
    join
    chk(hi == 5, "R11 current pulse keeps old high time", hi, 5);
    chk(per == 20, "R11 current pulse keeps old period", per, 20);
    measure(hi, per);
    chk(hi == 8, "R11 next pulse new high time", hi, 8);
    chk(per == 12, "R11 next pulse new period", per, 12);

    // R10: clearing run on channel 0 drops the output
    wr(A_CTL0, 32'h200);
    @(negedge clk);
    chk(pwmOut == 1'b0, "R10 output low after run cleared", pwmOut, 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule